// File: doc/BRIEF.md
# Condition Flag Register and Branch Condition Evaluator

This block keeps the four arithmetic status flags of a processor datapath: negative (N), zero (Z), carry (C) and overflow (V). It tests a 4-bit condition code against them and returns one take/execute bit. The ALU updates the flags through an update port. In narrow mode, N and Z come from a single result word, and C and V come from the ALU's carry and overflow outputs. In wide mode, N and Z come from a high/low register pair that forms a double-width result, and C and V are left as they were.

Software can read the flags as a packed status word, with the flags in the top four bits and a fixed pattern set by a parameter below them. A status word write loads only the four flags; its lower bits are dropped. Every output is registered. The status read word always shows the current flag register. The take bit shows the condition code and the flags as they stood just before the clock edge that captured it.

Top module: `cond_flags_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all flags clear to 0, `take_o` becomes 0 and `sr_rdata_o` becomes four zero flag bits above the low `DW-4` bits of `STATUS_BASE`.
- R2: A narrow update (`upd_en_i`=1, `upd_wide_i`=0) loads N from `upd_res_lo_i[DW-1]`, Z from (`upd_res_lo_i`==0), C from `upd_carry_i` and V from `upd_ovf_i` at that clock edge.
- R3: A wide update (`upd_en_i`=1, `upd_wide_i`=1) loads N from `upd_res_hi_i[DW-1]` and sets Z only when both `upd_res_hi_i` and `upd_res_lo_i` are zero; C and V keep their values.
- R4: `sr_rdata_o` places N at bit DW-1, Z at DW-2, C at DW-3 and V at DW-4, and its low `DW-4` bits always equal the low bits of `STATUS_BASE`. It reflects the flag register in the same cycle the flags change.
- R5: A status write (`sw_we_i`=1) loads N, Z, C and V from `sw_wdata_i` bits DW-1, DW-2, DW-3 and DW-4. The low `DW-4` bits of `sw_wdata_i` have no effect on the read word.
- R6: When a status write and a flag update come at the same edge, the status write decides all four flags.
- R7: With neither `upd_en_i` nor `sw_we_i` asserted, the flags and `sr_rdata_o` hold their values whatever the other inputs do.
- R8: Codes 0..7 are taken when, in order: Z=1, Z=0, C=1, C=0, N=1, N=0, V=1, V=0.
- R9: Code 8 is taken when C=1 and Z=0. Code 9 is taken when C=0 or Z=1.
- R10: Code 10 is taken when N==V, 11 when N!=V, 12 when Z=0 and N==V, 13 when Z=1 or N!=V.
- R11: Code 14 is always taken. Code 15 is never taken.
- R12: `take_o` is registered. After an edge it shows the code on `cond_i` evaluated against the flags held before that edge, so an update at the same edge is seen one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_en_i | input | 1 | ALU flag update enable |
| upd_wide_i | input | 1 | Selects the double-width update mode |
| upd_res_lo_i | input | DW | Result word, low word in wide mode |
| upd_res_hi_i | input | DW | High result word, used in wide mode |
| upd_carry_i | input | 1 | Carry from the ALU |
| upd_ovf_i | input | 1 | Signed overflow from the ALU |
| sw_we_i | input | 1 | Status word write enable |
| sw_wdata_i | input | DW | Status word to write |
| cond_i | input | 4 | Condition code to evaluate |
| take_o | output | 1 | Registered condition result |
| sr_rdata_o | output | DW | Registered packed status word |

## Verification
The bench builds the block with `DW`=16 and `STATUS_BASE`=16'h00A5. The flags then sit at bits 15..12, which shows that their positions follow the width parameter rather than fixed numbers. The non-zero base pattern makes any leak of written low bits or update data into the status word visible. With narrow words, a wide update whose low word alone is zero, or whose high word alone is non-zero, is easy to set up. All sixteen flag combinations are crossed with all sixteen codes.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } flags_t;

  // Code order is part of the behaviour: decoders upstream emit these values.
  localparam logic [3:0] COND_EQ = 4'd0;
  localparam logic [3:0] COND_NE = 4'd1;
  localparam logic [3:0] COND_CS = 4'd2;
  localparam logic [3:0] COND_CC = 4'd3;
  localparam logic [3:0] COND_MI = 4'd4;
  localparam logic [3:0] COND_PL = 4'd5;
  localparam logic [3:0] COND_VS = 4'd6;
  localparam logic [3:0] COND_VC = 4'd7;
  localparam logic [3:0] COND_HI = 4'd8;
  localparam logic [3:0] COND_LS = 4'd9;
  localparam logic [3:0] COND_GE = 4'd10;
  localparam logic [3:0] COND_LT = 4'd11;
  localparam logic [3:0] COND_GT = 4'd12;
  localparam logic [3:0] COND_LE = 4'd13;
  localparam logic [3:0] COND_AL = 4'd14;
  localparam logic [3:0] COND_NV = 4'd15;

endpackage

// File: rtl/cfu_flag_next.sv
module cfu_flag_next
  import cfu_pkg::*;
#(
  parameter int DW = 32
) (
  input  flags_t        flags_q,
  input  logic          upd_en_i,
  input  logic          upd_wide_i,
  input  logic [DW-1:0] upd_res_lo_i,
  input  logic [DW-1:0] upd_res_hi_i,
  input  logic          upd_carry_i,
  input  logic          upd_ovf_i,
  input  logic          sw_we_i,
  input  logic [3:0]    sw_flags_i,
  output flags_t        flags_d
);

  logic   lo_zero;
  logic   hi_zero;
  flags_t alu_flags;

  assign lo_zero = (upd_res_lo_i == '0);
  assign hi_zero = (upd_res_hi_i == '0);

  always_comb begin
    if (upd_wide_i) begin
      alu_flags.n = upd_res_hi_i[DW-1];
      alu_flags.z = lo_zero & hi_zero;
      alu_flags.c = flags_q.c;
      alu_flags.v = flags_q.v;
    end else begin
      alu_flags.n = upd_res_lo_i[DW-1];
      alu_flags.z = lo_zero;
      alu_flags.c = upd_carry_i;
      alu_flags.v = upd_ovf_i;
    end
  end

  // Status write has priority over the ALU update.
  always_comb begin
    if (sw_we_i)       flags_d = flags_t'(sw_flags_i);
    else if (upd_en_i) flags_d = alu_flags;
    else               flags_d = flags_q;
  end

endmodule

// File: rtl/cfu_cond_eval.sv
module cfu_cond_eval
  import cfu_pkg::*;
(
  input  logic [3:0] cond_i,
  input  flags_t     flags_i,
  output logic       take_o
);

  logic sgn_ok;
  assign sgn_ok = (flags_i.n == flags_i.v);

  always_comb begin
    case (cond_i)
      COND_EQ: take_o =  flags_i.z;
      COND_NE: take_o = ~flags_i.z;
      COND_CS: take_o =  flags_i.c;
      COND_CC: take_o = ~flags_i.c;
      COND_MI: take_o =  flags_i.n;
      COND_PL: take_o = ~flags_i.n;
      COND_VS: take_o =  flags_i.v;
      COND_VC: take_o = ~flags_i.v;
      COND_HI: take_o =  flags_i.c & ~flags_i.z;
      COND_LS: take_o = ~flags_i.c |  flags_i.z;
      COND_GE: take_o =  sgn_ok;
      COND_LT: take_o = ~sgn_ok;
      COND_GT: take_o = ~flags_i.z & sgn_ok;
      COND_LE: take_o =  flags_i.z | ~sgn_ok;
      COND_AL: take_o = 1'b1;
      default: take_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/cfu_status_pack.sv
module cfu_status_pack
  import cfu_pkg::*;
#(
  parameter int            DW          = 32,
  parameter logic [DW-1:0] STATUS_BASE = '0
) (
  input  flags_t        flags_i,
  output logic [DW-1:0] word_o
);

  localparam int LOW_W = DW - 4;

  assign word_o = {flags_i.n, flags_i.z, flags_i.c, flags_i.v,
                   STATUS_BASE[LOW_W-1:0]};

endmodule

// File: rtl/cond_flags_unit.sv
module cond_flags_unit
  import cfu_pkg::*;
#(
  parameter int            DW          = 32,
  parameter logic [DW-1:0] STATUS_BASE = 32'h0000_00D3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_en_i,
  input  logic          upd_wide_i,
  input  logic [DW-1:0] upd_res_lo_i,
  input  logic [DW-1:0] upd_res_hi_i,
  input  logic          upd_carry_i,
  input  logic          upd_ovf_i,
  input  logic          sw_we_i,
  input  logic [DW-1:0] sw_wdata_i,
  input  logic [3:0]    cond_i,
  output logic          take_o,
  output logic [DW-1:0] sr_rdata_o
);

  localparam int LOW_W = DW - 4;

  flags_t        flags_q;
  flags_t        flags_d;
  logic          take_d;
  logic [DW-1:0] word_d;
  logic          unused_wlow;

  assign unused_wlow = ^sw_wdata_i[LOW_W-1:0];

  cfu_flag_next #(.DW(DW)) u_next (
    .flags_q      (flags_q),
    .upd_en_i     (upd_en_i),
    .upd_wide_i   (upd_wide_i),
    .upd_res_lo_i (upd_res_lo_i),
    .upd_res_hi_i (upd_res_hi_i),
    .upd_carry_i  (upd_carry_i),
    .upd_ovf_i    (upd_ovf_i),
    .sw_we_i      (sw_we_i),
    .sw_flags_i   (sw_wdata_i[DW-1:LOW_W]),
    .flags_d      (flags_d)
  );

  cfu_cond_eval u_eval (
    .cond_i  (cond_i),
    .flags_i (flags_q),
    .take_o  (take_d)
  );

  // Packed from the next-state flags so the read word lines up with flags_q.
  cfu_status_pack #(.DW(DW), .STATUS_BASE(STATUS_BASE)) u_pack (
    .flags_i (flags_d),
    .word_o  (word_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q    <= '0;
      take_o     <= 1'b0;
      sr_rdata_o <= {4'b0000, STATUS_BASE[LOW_W-1:0]};
    end else begin
      flags_q    <= flags_d;
      take_o     <= take_d;
      sr_rdata_o <= word_d;
    end
  end

endmodule

// File: rtl/cfu_checker.sv
module cfu_checker #(
  parameter int            DW          = 32,
  parameter logic [DW-1:0] STATUS_BASE = '0
) (
  input logic          clk,
  input logic          rst,
  input logic          upd_en_i,
  input logic          upd_wide_i,
  input logic [DW-1:0] upd_res_lo_i,
  input logic          sw_we_i,
  input logic [DW-1:0] sw_wdata_i,
  input logic [3:0]    cond_i,
  input logic          take_o,
  input logic [DW-1:0] sr_rdata_o
);

  localparam int LOW_W = DW - 4;

  a_r4_low_bits_fixed: assert property (@(posedge clk) disable iff (rst)
    sr_rdata_o[LOW_W-1:0] == STATUS_BASE[LOW_W-1:0]);

  a_r5_write_loads_flags: assert property (@(posedge clk) disable iff (rst)
    sw_we_i |=> sr_rdata_o[DW-1:LOW_W] == $past(sw_wdata_i[DW-1:LOW_W]));

  a_r3_wide_keeps_cv: assert property (@(posedge clk) disable iff (rst)
    (upd_en_i && upd_wide_i && !sw_we_i)
      |=> sr_rdata_o[DW-3:DW-4] == $past(sr_rdata_o[DW-3:DW-4]));

  a_r2_narrow_zero: assert property (@(posedge clk) disable iff (rst)
    (upd_en_i && !upd_wide_i && !sw_we_i)
      |=> sr_rdata_o[DW-2] == ($past(upd_res_lo_i) == '0));

  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (!upd_en_i && !sw_we_i) |=> $stable(sr_rdata_o));

  a_r11_always: assert property (@(posedge clk) disable iff (rst)
    (cond_i == 4'd14) |=> take_o);

  a_r11_never: assert property (@(posedge clk) disable iff (rst)
    (cond_i == 4'd15) |=> !take_o);

endmodule

bind cond_flags_unit cfu_checker #(.DW(DW), .STATUS_BASE(STATUS_BASE)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .upd_en_i     (upd_en_i),
  .upd_wide_i   (upd_wide_i),
  .upd_res_lo_i (upd_res_lo_i),
  .sw_we_i      (sw_we_i),
  .sw_wdata_i   (sw_wdata_i),
  .cond_i       (cond_i),
  .take_o       (take_o),
  .sr_rdata_o   (sr_rdata_o)
);

// File: tb/tb_cond_flags_unit.sv
module tb_cond_flags_unit;

  localparam int            BW    = 16;
  localparam logic [BW-1:0] BASE  = 16'h00A5;
  localparam int            CLK_P = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          upd_en = 1'b0;
  logic          upd_wide = 1'b0;
  logic [BW-1:0] res_lo = '0;
  logic [BW-1:0] res_hi = '0;
  logic          carry = 1'b0;
  logic          ovf = 1'b0;
  logic          sw_we = 1'b0;
  logic [BW-1:0] wdata = '0;
  logic [3:0]    cond = 4'd15;
  logic          take;
  logic [BW-1:0] rdata;

  int nchk = 0;
  int nerr = 0;
  logic [3:0] mf = 4'b0000;  // model flags {N,Z,C,V}

  always #(CLK_P/2) clk = ~clk;

  cond_flags_unit #(.DW(BW), .STATUS_BASE(BASE)) dut (
    .clk(clk), .rst(rst),
    .upd_en_i(upd_en), .upd_wide_i(upd_wide),
    .upd_res_lo_i(res_lo), .upd_res_hi_i(res_hi),
    .upd_carry_i(carry), .upd_ovf_i(ovf),
    .sw_we_i(sw_we), .sw_wdata_i(wdata),
    .cond_i(cond), .take_o(take), .sr_rdata_o(rdata)
  );

  task automatic check(string req, logic [BW-1:0] act, logic [BW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] word_of(logic [3:0] f);
    return {f, BASE[BW-5:0]};
  endfunction

  function automatic logic exp_take(logic [3:0] c, logic [3:0] f);
    logic n, z, cy, v;
    {n, z, cy, v} = f;
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic do_write(logic [BW-1:0] w);
    @(negedge clk); sw_we = 1'b1; wdata = w;
    @(negedge clk); sw_we = 1'b0; wdata = 16'h3C3C;
    mf = w[BW-1:BW-4];
  endtask

  task automatic do_update(logic wide, logic [BW-1:0] lo, logic [BW-1:0] hi,
                           logic c, logic v);
    @(negedge clk);
    upd_en = 1'b1; upd_wide = wide; res_lo = lo; res_hi = hi; carry = c; ovf = v;
    @(negedge clk);
    upd_en = 1'b0; upd_wide = 1'b0; res_lo = 16'h1234; res_hi = 16'h8765;
    carry = 1'b1; ovf = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset status word", rdata, word_of(4'b0000));
    check("R1 reset take", {15'd0, take}, '0);
  endtask

  task automatic t_narrow();
    do_update(1'b0, 16'h8001, 16'h0000, 1'b1, 1'b0);
    check("R2 narrow neg carry", rdata, word_of(4'b1010));
    do_update(1'b0, 16'h0000, 16'hFFFF, 1'b0, 1'b1);
    check("R2 narrow zero ovf", rdata, word_of(4'b0101));
    do_update(1'b0, 16'h7FFF, 16'h8000, 1'b1, 1'b1);
    check("R2 narrow pos c v", rdata, word_of(4'b0011));
  endtask

  task automatic t_wide();
    do_write(16'h3000);
    do_update(1'b1, 16'h0000, 16'h0000, 1'b0, 1'b0);
    check("R3 wide both zero, C V kept", rdata, word_of(4'b0111));
    do_update(1'b1, 16'h0001, 16'h8000, 1'b0, 1'b0);
    check("R3 wide high negative", rdata, word_of(4'b1011));
    do_update(1'b1, 16'h0000, 16'h0001, 1'b0, 1'b0);
    check("R3 wide only low zero", rdata, word_of(4'b0011));
    do_write(16'h0000);
    do_update(1'b1, 16'h0000, 16'h0000, 1'b1, 1'b1);
    check("R3 wide ignores carry/ovf", rdata, word_of(4'b0100));
  endtask

  task automatic t_write();
    do_write(16'hAFFF);
    check("R5 R4 write with low ones", rdata, word_of(4'b1010));
    do_write(16'h5000);
    check("R5 R4 write low zeros", rdata, word_of(4'b0101));
  endtask

  task automatic t_collide();
    do_write(16'h0000);
    @(negedge clk);
    sw_we = 1'b1; wdata = 16'hC000;
    upd_en = 1'b1; upd_wide = 1'b0; res_lo = 16'h0001; carry = 1'b1; ovf = 1'b1;
    @(negedge clk);
    sw_we = 1'b0; upd_en = 1'b0;
    mf = 4'b1100;
    check("R6 write wins over update", rdata, word_of(4'b1100));
  endtask

  task automatic t_hold();
    do_write(16'h9000);
    @(negedge clk);
    res_lo = 16'h0000; res_hi = 16'h0000; upd_wide = 1'b1;
    carry = 1'b0; ovf = 1'b0; wdata = 16'h6FFF;
    repeat (3) @(negedge clk);
    upd_wide = 1'b0;
    check("R7 hold without enables", rdata, word_of(4'b1001));
  endtask

  task automatic t_conds();
    for (int f = 0; f < 16; f++) begin
      do_write({f[3:0], 12'h000});
      for (int c = 0; c < 16; c++) begin
        @(negedge clk); cond = c[3:0];
        @(negedge clk);
        if (c < 8)       check("R8 simple codes", {15'd0, take}, {15'd0, exp_take(c[3:0], mf)});
        else if (c < 10) check("R9 HI/LS codes", {15'd0, take}, {15'd0, exp_take(c[3:0], mf)});
        else if (c < 14) check("R10 signed codes", {15'd0, take}, {15'd0, exp_take(c[3:0], mf)});
        else             check("R11 always/never", {15'd0, take}, {15'd0, exp_take(c[3:0], mf)});
      end
    end
    cond = 4'd15;
  endtask

  task automatic t_timing();
    do_write(16'h0000);
    @(negedge clk);
    cond = 4'd0;
    upd_en = 1'b1; upd_wide = 1'b0; res_lo = 16'h0000; carry = 1'b0; ovf = 1'b0;
    @(negedge clk);
    upd_en = 1'b0;
    check("R12 take uses pre-edge flags", {15'd0, take}, 16'd0);
    @(negedge clk);
    check("R12 take sees update next cycle", {15'd0, take}, 16'd1);
    cond = 4'd15;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    rst = 1'b0;
    t_narrow();
    t_wide();
    t_write();
    t_collide();
    t_hold();
    t_conds();
    t_timing();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    nchk++;
    nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule